// File: doc/BRIEF.md
# Reciprocal Frequency Meter with Edge-Aligned Window

The block measures an unknown input frequency by timing a whole number of its own periods against a fixed reference clock, which gives the same relative resolution at low and high input rates. Software writes a window length in reference cycles and pulses a start request. The reference-domain controller raises a preset gate. The gate is re-timed into the measured-signal domain, so the real counting window opens and closes on rising edges of the measured signal. While that window is open, two enabled counters run side by side: one counts input periods and the other counts reference cycles. When the window has closed, both totals are latched together with a signed fine-interval correction, and a one-cycle done pulse is raised.

The correction is the difference between two fine interpolation counts taken at the opening and closing edges by an external delay-line interpolator. Each fine step is a fixed fraction 1/2^TD_SHIFT of a reference period. The block also reports the window length in fine steps, which is the reference count scaled by 2^TD_SHIFT plus the correction. A sticky flag reports a wrap of either counter during the window. Converting the two totals to hertz is done elsewhere.

The controller has five states. IDLE waits for start and goes to ARM. ARM holds the preset gate high until the re-timed window is seen open, then goes to GATE. GATE keeps the gate high for the programmed number of cycles, then goes to DRAIN. DRAIN holds the gate low until the window is seen closed, latches the results and goes to DONE. DONE lasts one cycle and returns to IDLE.

Top module: `recip_freq_meter`

## Requirements
- R1: After reset, done, busy, ovf, n_sig, n_ref, corr and interval are all zero.
- R2: start is taken only in IDLE, and busy is high on the next cycle. A start pulse while busy is ignored: the measurement gives a single done and its counts are not cleared.
- R3: The window begins and ends on rising edges of sig_in, so n_sig is an exact count of whole input periods. n_sig is nonzero, and |n_ref·Tref − n_sig·Tsig| < Tref.
- R4: The preset gate stays high for max(gate_len,1) reference cycles after the window is seen open. n_ref is at least that value and exceeds it by no more than the resync latency, which is 3·Tsig/Tref + 8 cycles.
- R5: corr equals fine_n1 − fine_n2 as a two's-complement value of FINE_W+1 bits, sampled in the cycle the results are latched.
- R6: interval equals n_ref·2^TD_SHIFT + corr, in two's complement of IVL_W = CNT_W+TD_SHIFT+1 bits.
- R7: done is high for exactly one reference cycle per measurement. All results hold their values until the next done.
- R8: ovf is 1 when either count wrapped past 2^CNT_W−1 during that window. A later window without a wrap clears it.
- R9: busy stays high from the cycle after an accepted start through the done cycle, and is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sig_in | input | 1 | Measured signal, used as the clock of the window logic |
| start | input | 1 | One-cycle request to begin a measurement |
| gate_len | input | GATE_W | Preset window length in reference cycles, taken at start |
| fine_n1 | input | FINE_W | Fine interpolation count at the opening edge |
| fine_n2 | input | FINE_W | Fine interpolation count at the closing edge |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when new results are latched |
| n_sig | output | CNT_W | Whole input periods in the window |
| n_ref | output | CNT_W | Reference cycles in the window |
| corr | output | FINE_W+1 | Signed fine correction fine_n1 − fine_n2 |
| interval | output | CNT_W+TD_SHIFT+1 | Window length in fine steps |
| ovf | output | 1 | A count wrapped during the last window |

## Verification
On every cycle, the embedded properties check that done is a single-cycle pulse raised only after the re-timed window has closed, that latched results change only together with done, that an accepted start raises busy, and that the input-period counter stays frozen while the window is shut. The bench scenarios cover what depends on two unrelated clocks running together: the match between the period count and the reference count, the window length against the programmed gate, the correction and interval arithmetic, both kinds of wrap, and a stray start in the middle of a measurement.

// File: rtl/recip_freq_meter_pkg.sv
package recip_freq_meter_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_GATE,
        S_DRAIN,
        S_DONE
    } meter_state_e;

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fm_sig_window.sv
module fm_sig_window #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             sig_clk,
    input  logic             rst_n,
    input  logic             pgate,
    output logic             win_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic             gate_s;
    logic             win_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    fm_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk   (sig_clk),
        .rst_n (rst_n),
        .d     (pgate),
        .q     (gate_s)
    );

    // Window flop follows the re-timed gate on measured-signal edges only.
    always_ff @(posedge sig_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            win_q <= gate_s;
            if (gate_s && !win_q) begin
                cnt_q <= '0;
                ovf_q <= 1'b0;
            end else if (win_q) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (&cnt_q) ovf_q <= 1'b1;
            end
        end
    end

    assign win_o = win_q;
    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R3: period counter is frozen while the window is shut and not opening
    p_sig_frozen_r3: assert property (@(posedge sig_clk) disable iff (!rst_n)
        (!win_q && !gate_s) |=> $stable(cnt_q));
endmodule

// File: rtl/fm_ref_ctrl.sv
module fm_ref_ctrl
    import recip_freq_meter_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int GATE_W   = 28,
    parameter int FINE_W   = 8,
    parameter int TD_SHIFT = 4,
    localparam int IVL_W   = CNT_W + TD_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [GATE_W-1:0] gate_len,
    input  logic [FINE_W-1:0] fine_n1,
    input  logic [FINE_W-1:0] fine_n2,
    input  logic              ref_win,
    input  logic [CNT_W-1:0]  sig_cnt,
    input  logic              sig_ovf,
    output logic              pgate_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  n_sig_o,
    output logic [CNT_W-1:0]  n_ref_o,
    output logic [FINE_W:0]   corr_o,
    output logic [IVL_W-1:0]  ivl_o,
    output logic              ovf_o
);
    meter_state_e state_q, state_d;

    logic [GATE_W-1:0] len_q;
    logic [GATE_W-1:0] tmr_q;
    logic [CNT_W-1:0]  ref_cnt_q;
    logic              ref_ovf_q;
    logic              pgate_q, pgate_d;
    logic              done_q, done_d;
    logic              cap;
    logic              gate_last;

    logic [CNT_W-1:0]  n_sig_q, n_ref_q;
    logic [FINE_W:0]   corr_q;
    logic [IVL_W-1:0]  ivl_q;
    logic              ovf_q;

    logic signed [FINE_W:0] corr_d;
    logic [IVL_W-1:0]       base_d, ivl_d;

    assign gate_last = ({1'b0, tmr_q} + (GATE_W+1)'(1)) >= {1'b0, len_q};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)     state_d = S_ARM;
            S_ARM:   if (ref_win)   state_d = S_GATE;
            S_GATE:  if (gate_last) state_d = S_DRAIN;
            S_DRAIN: if (!ref_win)  state_d = S_DONE;
            S_DONE:                 state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // Output decode, registered below so the crossing gate is glitch free
    always_comb begin
        pgate_d = (state_d == S_ARM) || (state_d == S_GATE);
        done_d  = (state_d == S_DONE);
        cap     = (state_q == S_DRAIN) && !ref_win;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pgate_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pgate_q <= pgate_d;
            done_q  <= done_d;
        end
    end

    assign corr_d = $signed({1'b0, fine_n1}) - $signed({1'b0, fine_n2});
    assign base_d = IVL_W'(ref_cnt_q) << TD_SHIFT;
    assign ivl_d  = base_d + {{(IVL_W-FINE_W-1){corr_d[FINE_W]}}, corr_d};

    // Timer, reference counter and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            tmr_q     <= '0;
            ref_cnt_q <= '0;
            ref_ovf_q <= 1'b0;
            n_sig_q   <= '0;
            n_ref_q   <= '0;
            corr_q    <= '0;
            ivl_q     <= '0;
            ovf_q     <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                len_q     <= gate_len;
                ref_cnt_q <= '0;
                ref_ovf_q <= 1'b0;
            end else if (ref_win) begin
                ref_cnt_q <= ref_cnt_q + CNT_W'(1);
                if (&ref_cnt_q) ref_ovf_q <= 1'b1;
            end

            if (state_q == S_ARM)       tmr_q <= '0;
            else if (state_q == S_GATE) tmr_q <= tmr_q + GATE_W'(1);

            if (cap) begin
                n_sig_q <= sig_cnt;
                n_ref_q <= ref_cnt_q;
                corr_q  <= corr_d;
                ivl_q   <= ivl_d;
                ovf_q   <= ref_ovf_q | sig_ovf;
            end
        end
    end

    assign pgate_o = pgate_q;
    assign busy_o  = (state_q != S_IDLE);
    assign done_o  = done_q;
    assign n_sig_o = n_sig_q;
    assign n_ref_o = n_ref_q;
    assign corr_o  = corr_q;
    assign ivl_o   = ivl_q;
    assign ovf_o   = ovf_q;

    // R7: done never lasts two cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4: results are only announced once the re-timed window has closed
    p_done_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !ref_win);

    // R7: latched results move only together with done
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> ($stable(n_ref_q) && $stable(n_sig_q) && $stable(corr_q)));

    // R2: an accepted start makes the block busy on the next cycle
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_o) |=> busy_o);
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter #(
    parameter int CNT_W       = 32,
    parameter int GATE_W      = 28,
    parameter int FINE_W      = 8,
    parameter int TD_SHIFT    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IVL_W      = CNT_W + TD_SHIFT + 1
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              start,
    input  logic [GATE_W-1:0] gate_len,
    input  logic [FINE_W-1:0] fine_n1,
    input  logic [FINE_W-1:0] fine_n2,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  n_sig,
    output logic [CNT_W-1:0]  n_ref,
    output logic [FINE_W:0]   corr,
    output logic [IVL_W-1:0]  interval,
    output logic              ovf
);
    logic             pgate;
    logic             win_sig;
    logic             win_ref;
    logic [CNT_W-1:0] sig_cnt;
    logic             sig_ovf;

    fm_sig_window #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_window (
        .sig_clk (sig_in),
        .rst_n   (rst_n),
        .pgate   (pgate),
        .win_o   (win_sig),
        .cnt_o   (sig_cnt),
        .ovf_o   (sig_ovf)
    );

    fm_sync #(.STAGES(SYNC_STAGES)) u_win_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (win_sig),
        .q     (win_ref)
    );

    fm_ref_ctrl #(
        .CNT_W    (CNT_W),
        .GATE_W   (GATE_W),
        .FINE_W   (FINE_W),
        .TD_SHIFT (TD_SHIFT)
    ) u_ctrl (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .start    (start),
        .gate_len (gate_len),
        .fine_n1  (fine_n1),
        .fine_n2  (fine_n2),
        .ref_win  (win_ref),
        .sig_cnt  (sig_cnt),
        .sig_ovf  (sig_ovf),
        .pgate_o  (pgate),
        .busy_o   (busy),
        .done_o   (done),
        .n_sig_o  (n_sig),
        .n_ref_o  (n_ref),
        .corr_o   (corr),
        .ivl_o    (interval),
        .ovf_o    (ovf)
    );
endmodule

// File: tb/recip_freq_meter_bench.sv
`timescale 1ns/100ps
module recip_freq_meter_bench;
    localparam int CNT_W    = 12;
    localparam int GATE_W   = 16;
    localparam int FINE_W   = 6;
    localparam int TD_SHIFT = 3;
    localparam int IVL_W    = CNT_W + TD_SHIFT + 1;
    localparam int TREF     = 8;

    logic              clk = 1'b0;
    logic              sig_in = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [GATE_W-1:0] gate_len = '0;
    logic [FINE_W-1:0] fine_n1 = '0;
    logic [FINE_W-1:0] fine_n2 = '0;
    logic              busy, done, ovf;
    logic [CNT_W-1:0]  n_sig, n_ref;
    logic [FINE_W:0]   corr;
    logic [IVL_W-1:0]  interval;

    int checks = 0;
    int errors = 0;
    int half   = 5;

    recip_freq_meter #(
        .CNT_W (CNT_W), .GATE_W (GATE_W), .FINE_W (FINE_W), .TD_SHIFT (TD_SHIFT)
    ) u_recip_freq_meter (
        .ref_clk (clk), .rst_n (rst_n), .sig_in (sig_in), .start (start),
        .gate_len (gate_len), .fine_n1 (fine_n1), .fine_n2 (fine_n2),
        .busy (busy), .done (done), .n_sig (n_sig), .n_ref (n_ref),
        .corr (corr), .interval (interval), .ovf (ovf)
    );

    // 125 MHz reference, offset so its edges never meet the integer-ns signal edges
    initial begin
        #0.25;
        forever #4 clk = ~clk;
    end

    always #(half) sig_in = ~sig_in;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint ref_upper(input int g, input int ts);
        return longint'(g) + (3 * ts) / TREF + 8;
    endfunction

    function automatic longint ivl_expect(input longint nr, input int n1, input int n2);
        logic [IVL_W-1:0] v;
        v = IVL_W'(nr * (1 << TD_SHIFT) + n1 - n2);
        return longint'(v);
    endfunction

    task automatic measure(input int ts, input int g, input int n1, input int n2,
                           input bit stray, input bit exp_ovf);
        int  waited;
        bit  got;
        int  extra;
        int  geff;
        longint nr, ns, diff;
        half     = ts / 2;
        gate_len = GATE_W'(g);
        fine_n1  = FINE_W'(n1);
        fine_n2  = FINE_W'(n2);
        geff     = (g == 0) ? 1 : g;
        repeat (12) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        chk(done == 1'b0, "R2", "no done right after start", done, 0);
        waited = 0;
        got    = 1'b0;
        while (!got && waited < 40000) begin
            @(negedge clk);
            waited++;
            if (done) got = 1'b1;
            start = (stray && waited == 15) ? 1'b1 : 1'b0;
        end
        start = 1'b0;
        chk(got, "R7", "done seen", got, 1);
        if (!got) return;
        nr = longint'(n_ref);
        ns = longint'(n_sig);
        chk(ovf == exp_ovf, "R8", "overflow flag", ovf, exp_ovf);
        if (!exp_ovf) begin
            diff = nr * TREF - ns * ts;
            chk(ns > 0, "R3", "period count nonzero", ns, 1);
            chk(diff < TREF && diff > -TREF, "R3", "ref time minus sig time", diff, 0);
            chk(nr >= geff && nr <= ref_upper(geff, ts), "R4", "ref count vs gate",
                nr, geff);
        end
        chk(int'($signed(corr)) == n1 - n2, "R5", "correction",
            int'($signed(corr)), n1 - n2);
        chk(longint'(interval) == ivl_expect(nr, n1, n2), "R6", "interval",
            longint'(interval), ivl_expect(nr, n1, n2));
        @(negedge clk);
        chk(done == 1'b0, "R7", "done width", done, 0);
        chk(busy == 1'b0, "R9", "busy after done", busy, 0);
        extra = 0;
        repeat (40) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, stray ? "R2" : "R7", "extra done pulses", extra, 0);
        chk(longint'(n_ref) == nr && longint'(n_sig) == ns, "R7", "results held",
            longint'(n_ref), nr);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual no finish expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0 && busy == 1'b0, "R1", "done/busy idle", {done, busy}, 0);
        chk(n_ref == '0 && n_sig == '0, "R1", "counts zero", n_ref, 0);
        chk(corr == '0 && interval == '0 && ovf == 1'b0, "R1", "corr/interval/ovf zero",
            interval, 0);

        // Directed corners
        measure(10, 50, 7, 3, 1'b0, 1'b0);     // 100 MHz input
        measure(46, 0, 0, 63, 1'b0, 1'b0);     // zero gate acts as one, negative corr
        measure(4, 1, 63, 0, 1'b0, 1'b0);      // minimum gate, fastest input
        measure(22, 120, 20, 20, 1'b1, 1'b0);  // R2 stray start mid-window
        measure(4, 2100, 5, 9, 1'b0, 1'b1);    // R8 signal count wraps
        measure(40, 4200, 9, 5, 1'b0, 1'b1);   // R8 reference count wraps
        measure(14, 80, 1, 2, 1'b0, 1'b0);     // R8 flag cleared again

        // Random mix
        for (int i = 0; i < 12; i++) begin
            measure(4 + 2 * int'($urandom % 30), 20 + int'($urandom % 300),
                    int'($urandom % 64), int'($urandom % 64), 1'b0, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end
endmodule